// File: doc/BRIEF.md
# Supervisor State-Save Sequencer

This unit handles one privileged state-save request from start to finish. On a start pulse it captures an instruction mask, two enable masks, the feature-enable flag, a control word, the privilege level, the save-area address, a 64-bit in-use vector and the floating-point control/status word. From these it derives the requested component set. It then decides whether the request faults.

A faulting request produces a single fault report and nothing else. A request that does not fault produces one header beat. That beat carries the header state bitmap and the compaction bitmap. After the header, the unit walks the components that need saving, lowest index first, and offers each one on a valid/ready port together with a flag that tells whether it lives in the extended region. A one-cycle done pulse closes every request that did not fault.

The surrounding datapath moves the memory data and computes offsets. This block only decides and orders the work.

Top module: `ssave_ctrl`

## Requirements
- R1: The requested set is `imask_i & (enmask_a_i | enmask_b_i)`, taken from the values present on the start cycle.
- R2: Fault code 1 is reported when `feat_on_i` is 0. Otherwise code 2 is reported when bit 3 of `ctl_reg_i` is 1. Otherwise code 3 is reported when `priv_i` is nonzero or `area_addr_i[5:0]` is nonzero. Otherwise there is no fault (code 0).
- R3: A faulting request gives exactly one cycle of `fault_vld_o`, one cycle after start, and then returns idle. It gives no header beat, no save request and no done pulse.
- R4: On the header beat, bit i of `hdr_state_o` is requested bit i AND in-use bit i, for every i from 0 to 63.
- R5: When requested bit 1 is set and `fpcsr_i` differs from 32'h1F80, `hdr_state_o[1]` is 1 and component 1 is saved, even if in-use bit 1 is 0.
- R6: On the header beat, `hdr_comp_o[62:0]` equals requested bits 62:0 and `hdr_comp_o[63]` is 1.
- R7: The components saved are exactly the set bits 0 to 62 of the header state bitmap. They are offered in ascending index, one per accepted handshake (`sv_vld_o` and `sv_rdy_i` both high). Index and valid are held while ready is low. The header beat comes one cycle after start, and the first save request comes in the cycle after the header beat.
- R8: `sv_ext_o` is 1 with a save request exactly when the offered index is 2 or more (extended region, compacted layout). It is 0 for components 0 and 1.
- R9: `done_o` pulses for one cycle, in the cycle after the last accepted handshake, or in the cycle after the header beat when nothing needs saving.
- R10: Start is accepted only while `busy_o` is low. A start pulse during a busy request, and any input change after the start cycle, has no effect on that request's outputs.
- R11: After reset, and whenever they are not being reported, all valid, done and busy outputs are 0, and the fault code, bitmaps and index read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a save request (taken when idle) |
| imask_i | input | 64 | Instruction component mask |
| enmask_a_i | input | 64 | First enable mask |
| enmask_b_i | input | 64 | Second (supervisor) enable mask |
| feat_on_i | input | 1 | Save feature enabled |
| ctl_reg_i | input | 32 | Control word, bit 3 = task-switched |
| priv_i | input | 2 | Current privilege level |
| area_addr_i | input | 64 | Save-area address |
| inuse_i | input | 64 | Per-component in-use vector |
| fpcsr_i | input | 32 | Floating-point control/status value |
| fault_vld_o | output | 1 | Fault report strobe |
| fault_code_o | output | 2 | 1 invalid opcode, 2 device not available, 3 general protection |
| hdr_vld_o | output | 1 | Header bitmap beat |
| hdr_state_o | output | 64 | Header state bitmap |
| hdr_comp_o | output | 64 | Header compaction bitmap |
| sv_vld_o | output | 1 | Component save request valid |
| sv_rdy_i | input | 1 | Component save request accepted |
| sv_idx_o | output | 6 | Component index |
| sv_ext_o | output | 1 | Component is in the extended region |
| done_o | output | 1 | Request complete |
| busy_o | output | 1 | Request in progress |

## Verification
Directed requests separate the in-use filter from the requested set. They cover a control/status word at its reset value and away from it with in-use bit 1 clear, which shows whether the forced save of component 1 follows the right condition. Fault cases combine several causes at once, which exposes the wrong priority order. A full-mask request walks components 0 to 62 under a random ready pattern to test ordering, hold-while-stalled and the boundary at bit 63. Random requests, with inputs scrambled after start and extra start pulses sent mid-request, confirm that capture happens only on the start cycle.

// File: rtl/ssave_pkg.sv
package ssave_pkg;
   typedef enum logic [1:0] {
      FLT_NONE = 2'd0,
      FLT_UD   = 2'd1,
      FLT_NM   = 2'd2,
      FLT_GP   = 2'd3
   } fault_e;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_REPORT,
      SQ_SAVE,
      SQ_DONE
   } seq_e;
endpackage

// File: rtl/ssave_fault_chk.sv
module ssave_fault_chk
   import ssave_pkg::*;
#(
   parameter int CTL_W      = 32,
   parameter int TS_BIT     = 3,
   parameter int ALIGN_LOG2 = 6
) (
   input  logic                  feat_on,
   input  logic [CTL_W-1:0]      ctl_word,
   input  logic [1:0]            priv,
   input  logic [ALIGN_LOG2-1:0] addr_lo,
   output fault_e                fault
);
   logic aligned;
   logic unused_ctl;

   generate
      if (ALIGN_LOG2 == 0) begin : g_noalign
         assign aligned = 1'b1;
      end else begin : g_align
         assign aligned = (addr_lo == '0);
      end
   endgenerate

   assign unused_ctl = ^ctl_word;

   // Ordered checks: feature off, then task-switched, then privilege/alignment
   always_comb begin
      if (!feat_on)                   fault = FLT_UD;
      else if (ctl_word[TS_BIT])      fault = FLT_NM;
      else if (priv != 2'd0 || !aligned) fault = FLT_GP;
      else                            fault = FLT_NONE;
   end
endmodule

// File: rtl/ssave_mask_gen.sv
module ssave_mask_gen #(
   parameter int          NCOMP    = 64,
   parameter int          CSR_W    = 32,
   parameter logic [31:0] CSR_INIT = 32'h1F80,
   parameter int          FRC_IDX  = 1
) (
   input  logic [NCOMP-1:0] imask,
   input  logic [NCOMP-1:0] en_a,
   input  logic [NCOMP-1:0] en_b,
   input  logic [NCOMP-1:0] inuse,
   input  logic [CSR_W-1:0] csr,
   output logic [NCOMP-1:0] state_map,
   output logic [NCOMP-1:0] comp_map,
   output logic [NCOMP-1:0] save_set
);
   logic [NCOMP-1:0] req;
   logic             csr_dirty;

   assign req       = imask & (en_a | en_b);
   assign csr_dirty = (csr != CSR_INIT[CSR_W-1:0]);

   generate
      for (genvar i = 0; i < NCOMP; i++) begin : g_bit
         if (i == FRC_IDX) begin : g_frc
            assign state_map[i] = req[i] & (inuse[i] | csr_dirty);
         end else begin : g_plain
            assign state_map[i] = req[i] & inuse[i];
         end
         if (i == NCOMP - 1) begin : g_top
            assign comp_map[i] = 1'b1;
            assign save_set[i] = 1'b0;
         end else begin : g_low
            assign comp_map[i] = req[i];
            assign save_set[i] = state_map[i];
         end
      end
   endgenerate
endmodule

// File: rtl/ssave_seq.sv
module ssave_seq
   import ssave_pkg::*;
#(
   parameter int NCOMP      = 64,
   parameter int LEGACY_CNT = 2,
   localparam int IDX_W     = $clog2(NCOMP)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  fault_e           fault_in,
   input  logic [NCOMP-1:0] state_in,
   input  logic [NCOMP-1:0] comp_in,
   input  logic [NCOMP-1:0] save_in,
   output logic             fault_vld,
   output logic [1:0]       fault_code,
   output logic             hdr_vld,
   output logic [NCOMP-1:0] hdr_state,
   output logic [NCOMP-1:0] hdr_comp,
   output logic             sv_vld,
   input  logic             sv_rdy,
   output logic [IDX_W-1:0] sv_idx,
   output logic             sv_ext,
   output logic             done,
   output logic             busy
);
   localparam logic [NCOMP-1:0] ONE = NCOMP'(1);

   seq_e             st;
   fault_e           flt_q;
   logic [NCOMP-1:0] pend_q, st_q, cp_q, pend_rest;
   logic [IDX_W-1:0] low_idx;

   assign pend_rest = pend_q & (pend_q - ONE);

   always_comb begin
      low_idx = '0;
      for (int i = NCOMP - 1; i >= 0; i--) begin
         if (pend_q[i]) low_idx = IDX_W'(i);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= SQ_IDLE;
         flt_q  <= FLT_NONE;
         pend_q <= '0;
         st_q   <= '0;
         cp_q   <= '0;
      end else begin
         case (st)
            SQ_IDLE: if (start) begin
               flt_q  <= fault_in;
               pend_q <= save_in;
               st_q   <= state_in;
               cp_q   <= comp_in;
               st     <= SQ_REPORT;
            end
            SQ_REPORT: begin
               if (flt_q != FLT_NONE) st <= SQ_IDLE;
               else if (pend_q == '0)  st <= SQ_DONE;
               else                    st <= SQ_SAVE;
            end
            SQ_SAVE: if (sv_rdy) begin
               pend_q <= pend_rest;
               if (pend_rest == '0) st <= SQ_DONE;
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

   assign busy       = (st != SQ_IDLE);
   assign fault_vld  = (st == SQ_REPORT) && (flt_q != FLT_NONE);
   assign fault_code = (st == SQ_REPORT) ? flt_q : FLT_NONE;
   assign hdr_vld    = (st == SQ_REPORT) && (flt_q == FLT_NONE);
   assign hdr_state  = hdr_vld ? st_q : '0;
   assign hdr_comp   = hdr_vld ? cp_q : '0;
   assign sv_vld     = (st == SQ_SAVE);
   assign sv_idx     = sv_vld ? low_idx : '0;
   assign sv_ext     = sv_vld && (low_idx >= IDX_W'(LEGACY_CNT));
   assign done       = (st == SQ_DONE);
endmodule

// File: rtl/ssave_ctrl.sv
module ssave_ctrl
   import ssave_pkg::*;
#(
   parameter int          NCOMP      = 64,
   parameter int          ADDR_W     = 64,
   parameter int          CTL_W      = 32,
   parameter int          TS_BIT     = 3,
   parameter int          ALIGN_LOG2 = 6,
   parameter int          CSR_W      = 32,
   parameter logic [31:0] CSR_INIT   = 32'h1F80,
   localparam int         IDX_W      = $clog2(NCOMP)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [NCOMP-1:0]  imask_i,
   input  logic [NCOMP-1:0]  enmask_a_i,
   input  logic [NCOMP-1:0]  enmask_b_i,
   input  logic              feat_on_i,
   input  logic [CTL_W-1:0]  ctl_reg_i,
   input  logic [1:0]        priv_i,
   input  logic [ADDR_W-1:0] area_addr_i,
   input  logic [NCOMP-1:0]  inuse_i,
   input  logic [CSR_W-1:0]  fpcsr_i,
   output logic              fault_vld_o,
   output logic [1:0]        fault_code_o,
   output logic              hdr_vld_o,
   output logic [NCOMP-1:0]  hdr_state_o,
   output logic [NCOMP-1:0]  hdr_comp_o,
   output logic              sv_vld_o,
   input  logic              sv_rdy_i,
   output logic [IDX_W-1:0]  sv_idx_o,
   output logic              sv_ext_o,
   output logic              done_o,
   output logic              busy_o
);
   generate
      if (NCOMP < 3 || NCOMP > 64) begin : g_bad_ncomp
         $error("ssave_ctrl: NCOMP must lie in 3..64");
      end
      if (ALIGN_LOG2 < 1 || ALIGN_LOG2 >= ADDR_W) begin : g_bad_align
         $error("ssave_ctrl: ALIGN_LOG2 out of range");
      end
      if (TS_BIT >= CTL_W) begin : g_bad_ts
         $error("ssave_ctrl: TS_BIT outside control word");
      end
   endgenerate

   fault_e           fault_w;
   logic [NCOMP-1:0] state_w, comp_w, save_w;
   logic             unused_addr_hi;

   assign unused_addr_hi = ^area_addr_i[ADDR_W-1:ALIGN_LOG2];

   ssave_fault_chk #(.CTL_W(CTL_W), .TS_BIT(TS_BIT), .ALIGN_LOG2(ALIGN_LOG2)) u_fault (
      .feat_on  (feat_on_i),
      .ctl_word (ctl_reg_i),
      .priv     (priv_i),
      .addr_lo  (area_addr_i[ALIGN_LOG2-1:0]),
      .fault    (fault_w)
   );

   ssave_mask_gen #(.NCOMP(NCOMP), .CSR_W(CSR_W), .CSR_INIT(CSR_INIT), .FRC_IDX(1)) u_mask (
      .imask     (imask_i),
      .en_a      (enmask_a_i),
      .en_b      (enmask_b_i),
      .inuse     (inuse_i),
      .csr       (fpcsr_i),
      .state_map (state_w),
      .comp_map  (comp_w),
      .save_set  (save_w)
   );

   ssave_seq #(.NCOMP(NCOMP), .LEGACY_CNT(2)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start_i),
      .fault_in   (fault_w),
      .state_in   (state_w),
      .comp_in    (comp_w),
      .save_in    (save_w),
      .fault_vld  (fault_vld_o),
      .fault_code (fault_code_o),
      .hdr_vld    (hdr_vld_o),
      .hdr_state  (hdr_state_o),
      .hdr_comp   (hdr_comp_o),
      .sv_vld     (sv_vld_o),
      .sv_rdy     (sv_rdy_i),
      .sv_idx     (sv_idx_o),
      .sv_ext     (sv_ext_o),
      .done       (done_o),
      .busy       (busy_o)
   );
endmodule

// File: rtl/ssave_ctrl_chk.sv
module ssave_ctrl_chk #(
   parameter int NCOMP  = 64,
   localparam int IDX_W = $clog2(NCOMP)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             busy_o,
   input logic             fault_vld_o,
   input logic [1:0]       fault_code_o,
   input logic             hdr_vld_o,
   input logic [NCOMP-1:0] hdr_comp_o,
   input logic             sv_vld_o,
   input logic             sv_rdy_i,
   input logic [IDX_W-1:0] sv_idx_o,
   input logic             done_o
);
   // R3
   fault_hdr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(fault_vld_o && hdr_vld_o));
   // R2
   fault_code_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_vld_o |-> (fault_code_o != 2'd0));
   // R3
   fault_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_vld_o |=> !busy_o);
   // R6
   comp_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_vld_o |-> hdr_comp_o[NCOMP-1]);
   // R7
   hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sv_vld_o && !sv_rdy_i) |=> (sv_vld_o && $stable(sv_idx_o)));
   // R7
   ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sv_vld_o && sv_rdy_i) |=> (!sv_vld_o || (sv_idx_o > $past(sv_idx_o))));
   // R7
   no_top_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sv_vld_o |-> (sv_idx_o != IDX_W'(NCOMP - 1)));
   // R9
   done_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o);
   // R10
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> (busy_o && !done_o && !sv_vld_o));
endmodule

bind ssave_ctrl ssave_ctrl_chk #(.NCOMP(NCOMP)) u_chk (.*);

// File: tb/ssave_ctrl_tb.sv
module ssave_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int WDOG       = 150000;

   logic        clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
   logic [63:0] imask_i = '0, enmask_a_i = '0, enmask_b_i = '0, area_addr_i = '0, inuse_i = '0;
   logic        feat_on_i = 1'b0;
   logic [31:0] ctl_reg_i = '0, fpcsr_i = 32'h1F80;
   logic [1:0]  priv_i = '0;
   logic        sv_rdy_i = 1'b0;
   logic        fault_vld_o, hdr_vld_o, sv_vld_o, sv_ext_o, done_o, busy_o;
   logic [1:0]  fault_code_o;
   logic [63:0] hdr_state_o, hdr_comp_o;
   logic [5:0]  sv_idx_o;

   ssave_ctrl u_dut (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_cmp = 0, n_bad = 0, cyc = 0;
   bit rdy_rand = 1'b0;

   // behavioural reference
   int          m_phase;
   logic [1:0]  m_flt;
   logic [63:0] m_st, m_cp;
   int          m_q[$];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_phase = 0; m_flt = 0; m_st = 0; m_cp = 0; m_q.delete();
      end else begin
         case (m_phase)
            0: if (start_i) begin
               logic [63:0] rq;
               rq = imask_i & (enmask_a_i | enmask_b_i);                 // R1
               if (!feat_on_i) m_flt = 2'd1;                             // R2
               else if (ctl_reg_i[3]) m_flt = 2'd2;
               else if (priv_i != 0 || area_addr_i[5:0] != 0) m_flt = 2'd3;
               else m_flt = 2'd0;
               m_st = rq & inuse_i;                                      // R4
               if (rq[1] && fpcsr_i != 32'h1F80) m_st[1] = 1'b1;         // R5
               m_cp = {1'b1, rq[62:0]};                                  // R6
               m_q.delete();
               for (int i = 0; i < 63; i++) if (m_st[i]) m_q.push_back(i);
               m_phase = 1;
            end
            1: m_phase = (m_flt != 0) ? 0 : (m_q.size() == 0 ? 3 : 2);
            2: if (sv_rdy_i) begin
               void'(m_q.pop_front());
               if (m_q.size() == 0) m_phase = 3;
            end
            default: m_phase = 0;
         endcase
      end
   end

   task automatic cmp(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
      end
   endtask

   always @(negedge clk) begin
      logic ehv, esv;
      logic [63:0] eidx;
      cyc++;
      ehv  = (m_phase == 1) && (m_flt == 0);
      esv  = (m_phase == 2);
      eidx = esv ? 64'(m_q[0]) : 64'd0;
      cmp(busy_o == (m_phase != 0), "R10 busy", 64'(busy_o), 64'(m_phase != 0));
      cmp(fault_vld_o == ((m_phase == 1) && (m_flt != 0)), "R3 fault_vld", 64'(fault_vld_o), 64'((m_phase == 1) && (m_flt != 0)));
      cmp(fault_code_o == ((m_phase == 1) ? m_flt : 2'd0), "R2 fault_code", 64'(fault_code_o), 64'((m_phase == 1) ? m_flt : 2'd0));
      cmp(hdr_vld_o == ehv, "R3 hdr_vld", 64'(hdr_vld_o), 64'(ehv));
      cmp(hdr_state_o == (ehv ? m_st : 64'd0), "R4/R5 hdr_state", hdr_state_o, ehv ? m_st : 64'd0);
      cmp(hdr_comp_o == (ehv ? m_cp : 64'd0), "R1/R6 hdr_comp", hdr_comp_o, ehv ? m_cp : 64'd0);
      cmp(sv_vld_o == esv, "R7 sv_vld", 64'(sv_vld_o), 64'(esv));
      cmp(64'(sv_idx_o) == eidx, "R7 sv_idx", 64'(sv_idx_o), eidx);
      cmp(sv_ext_o == (esv && eidx >= 2), "R8 sv_ext", 64'(sv_ext_o), 64'(esv && eidx >= 2));
      cmp(done_o == (m_phase == 3), "R9 done", 64'(done_o), 64'(m_phase == 3));
      sv_rdy_i <= rdy_rand ? 1'($urandom % 2) : 1'b1;
   end

   always @(posedge clk) if (cyc > WDOG) begin
      n_bad++;
      $display("FAIL watchdog expired: actual %0d expected <= %0d", cyc, WDOG);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   task automatic run(input logic [63:0] im, ea, eb, iu, input logic fe, input logic [31:0] cr,
                      input logic [1:0] pl, input logic [63:0] ad, input logic [31:0] cs,
                      input bit poke);
      @(negedge clk);
      imask_i = im; enmask_a_i = ea; enmask_b_i = eb; inuse_i = iu; feat_on_i = fe;
      ctl_reg_i = cr; priv_i = pl; area_addr_i = ad; fpcsr_i = cs; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      // R10: scramble inputs after the start cycle
      imask_i = {$urandom, $urandom}; inuse_i = {$urandom, $urandom}; fpcsr_i = $urandom;
      feat_on_i = 1'($urandom); ctl_reg_i = $urandom;
      if (poke) begin
         @(negedge clk); start_i = 1'b1;   // R10: start while busy
         @(negedge clk); start_i = 1'b0;
      end
      while (busy_o) @(negedge clk);
      start_i = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      cmp(!busy_o && !sv_vld_o && !done_o && !hdr_vld_o && !fault_vld_o && hdr_state_o == 0,
          "R11 reset", 64'(busy_o), 64'd0);
      rst_n = 1'b1;
      // basic filter: saves 0 and 2
      run('1, 64'h7, 64'h0, 64'h5, 1, 0, 0, 64'h1000, 32'h1F80, 0);
      // R5 forced save of component 1
      run('1, 64'h3, 64'h0, 64'h0, 1, 0, 0, 64'h40, 32'h1FA0, 0);
      // R5 not forced at reset value
      run('1, 64'h3, 64'h0, 64'h0, 1, 0, 0, 64'h40, 32'h1F80, 0);
      // R2 fault ordering
      run('1, '1, '1, '1, 0, 32'h8, 3, 64'h21, 32'h1F80, 0);
      run('1, '1, '1, '1, 1, 32'h8, 3, 64'h21, 32'h1F80, 0);
      run('1, '1, '1, '1, 1, 32'h7, 3, 64'h0, 32'h1F80, 0);
      run('1, '1, '1, '1, 1, 32'h0, 0, 64'h20, 32'h1F80, 0);
      // R9 nothing to save
      run(64'hF0, 64'hFF, 64'h0, 64'h0, 1, 0, 0, 64'h0, 32'h1F80, 0);
      // R7 full walk with random ready, bit 63 requested
      rdy_rand = 1'b1;
      run('1, 64'h00FF_00FF_00FF_00FF, 64'hFF00_FF00_FF00_FF00, '1, 1, 0, 0, 64'h80, 32'h0, 1);
      // R1 supervisor mask only
      run(64'hAAAA_5555_0F0F_F0F0, 64'h0, 64'h0000_FFFF_FFFF_0000, '1, 1, 0, 0, 64'h0, 32'h1F80, 1);
      for (int k = 0; k < 40; k++) begin
         run({$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
             ($urandom % 8) != 0, ($urandom % 6 == 0) ? 32'h8 : 32'h0,
             ($urandom % 6 == 0) ? 2'd3 : 2'd0, ($urandom % 6 == 0) ? 64'h4 : 64'h0,
             ($urandom % 2) ? 32'h1F80 : 32'h1F81, k[0]);
      end
      repeat (3) @(negedge clk);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule